// File: doc/BRIEF.md
# Channel Control and Status Register Bank

This block is the register front end of one descriptor-driven DMA channel. Software reaches it through a 32-bit write port and a combinational read port, both selected by a byte address whose upper bits give a word index. It holds the channel status word, the command pointer and three condition-select registers used by the descriptor sequencer for interrupt, branch and wait decisions. It does not execute descriptors.

A control write never stores anything by itself. Its upper half is a per-bit enable and its lower half the new bit values. The merged result then goes through fixed precedence rules that derive the ACTIVE and DEAD bits. Three one-cycle pulses leave the block: a kick toward the sequencer, a flush request toward the device, and a fetch request after an accepted command-pointer write. The sequencer can abort the channel through a kill input. The block is built from four design modules: a status merge, an address decoder, a condition-select register and the top.

Top module: `dmareg_chan`

## Requirements
- R1: After reset the status, command pointer and all three select registers are zero, and kick_o, flush_o and fetch_o are low.
- R2: A write to word 0 (control) takes its enable mask from wr_data[31:16] and its value from wr_data[15:0]. Only status bits 15 (RUN), 14 (PAUSE), 13 (FLUSH), 12 (WAKE) and 7:0 (device condition bits) can take a written 1. A bit whose enable is 0 keeps its old value, and any other bit whose enable is 1 becomes 0 before the rules of R3 and R4 are applied.
- R3: After the merge, WAKE set makes ACTIVE (bit 10) 1. RUN set makes ACTIVE 1 and DEAD (bit 11) 0. PAUSE set is applied after both and forces ACTIVE to 0.
- R4: If a control write takes RUN from 1 to 0, ACTIVE and DEAD become 0. If FLUSH is 1 at that point, it is cleared and a flush request is raised.
- R5: In the cycle after a control write, kick_o is high exactly when the new status has ACTIVE set. flush_o is high exactly when FLUSH is still set in the new status or the R4 flush case occurred.
- R6: A write to word 2 (command pointer) is discarded while ACTIVE is set. Otherwise the pointer takes wr_data with bits 3:0 cleared, and fetch_o pulses in the following cycle.
- R7: Reading word 0 returns zero. Reading word 1 returns the status in bits 15:0, with zero above. Words 2 to 5 return the command pointer and the interrupt, branch and wait selects. Every other word reads zero, and writes to it have no effect.
- R8: The word index is addr divided by 4, so addr[1:0] has no influence on reads or writes.
- R9: seq_kill sets DEAD and clears ACTIVE. A control write in the same cycle is merged on top of the killed status.
- R10: Writes to word 1 leave the status unchanged. Words 3, 4 and 5 store all 32 written bits and drive intr_sel_o, branch_sel_o and wait_sel_o.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Write strobe for one cycle |
| addr | input | ADDR_W | Byte address within the channel |
| wr_data | input | 32 | Write data |
| rd_data | output | 32 | Read data for addr (combinational) |
| seq_kill | input | 1 | Sequencer abort: set DEAD, clear ACTIVE |
| status_o | output | 16 | Current status word |
| cmd_ptr_o | output | 32 | Current command pointer |
| intr_sel_o | output | 32 | Interrupt condition select |
| branch_sel_o | output | 32 | Branch condition select |
| wait_sel_o | output | 32 | Wait condition select |
| kick_o | output | 1 | Pulse: channel active after control write |
| flush_o | output | 1 | Pulse: flush request to the device |
| fetch_o | output | 1 | Pulse: descriptor fetch after pointer load |

## Verification
The bench builds the block with its defaults: ADDR_W = 6, which gives sixteen word slots, and three select registers. With so few slots, every index can be read at each offset within its word, so the unused slots and the ignored address bits are fully covered. The main sweep crosses all sixteen value patterns of RUN, PAUSE, FLUSH and WAKE with all sixteen enable patterns. It varies the enables on DEAD/ACTIVE and the device bits arithmetically and injects kills on a fixed stride, so every precedence path is reached, including RUN falling while FLUSH is set.

// File: rtl/dmareg_pkg.sv
package dmareg_pkg;
    localparam int DATA_W   = 32;
    localparam int ST_W     = 16;
    localparam int B_RUN    = 15;
    localparam int B_PAUSE  = 14;
    localparam int B_FLUSH  = 13;
    localparam int B_WAKE   = 12;
    localparam int B_DEAD   = 11;
    localparam int B_ACT    = 10;
    localparam int B_BT     = 8;
    localparam int DEV_W    = 8;
    localparam logic [ST_W-1:0] WR_MASK = 16'hF0FF;
    localparam int ALIGN_B  = 4;

    localparam int IDX_CTRL = 0;
    localparam int IDX_STAT = 1;
    localparam int IDX_CPTR = 2;
    localparam int IDX_SEL0 = 3;
endpackage

// File: rtl/dmareg_status_merge.sv
module dmareg_status_merge
    import dmareg_pkg::*;
(
    input  logic [ST_W-1:0]   cur,
    input  logic              kill,
    input  logic              wr,
    input  logic [DATA_W-1:0] wdata,
    output logic [ST_W-1:0]   nxt,
    output logic              kick_n,
    output logic              flush_n
);
    logic [ST_W-1:0] base;
    logic [ST_W-1:0] en;
    logic [ST_W-1:0] val;
    logic [ST_W-1:0] s;
    logic            fl;

    always_comb begin
        base = cur;
        if (kill) begin
            base[B_DEAD] = 1'b1;
            base[B_ACT]  = 1'b0;
        end
        en  = wdata[DATA_W-1:ST_W];
        val = wdata[ST_W-1:0] & WR_MASK;
        s   = (val & en) | (base & ~en);
        fl  = 1'b0;
        if (s[B_WAKE]) begin
            s[B_ACT] = 1'b1;
        end
        if (s[B_RUN]) begin
            s[B_ACT]  = 1'b1;
            s[B_DEAD] = 1'b0;
        end
        if (s[B_PAUSE]) begin
            s[B_ACT] = 1'b0;
        end
        if (base[B_RUN] && !s[B_RUN]) begin
            s[B_ACT]  = 1'b0;
            s[B_DEAD] = 1'b0;
            if (s[B_FLUSH]) begin
                fl         = 1'b1;
                s[B_FLUSH] = 1'b0;
            end
        end
        if (s[B_FLUSH]) begin
            fl = 1'b1;
        end
        nxt     = wr ? s : base;
        kick_n  = wr & s[B_ACT];
        flush_n = wr & fl;
    end
endmodule

// File: rtl/dmareg_decode.sv
module dmareg_decode
    import dmareg_pkg::*;
#(
    parameter int ADDR_W = 6,
    parameter int SEL_N  = 3
) (
    input  logic [ADDR_W-1:0]           addr,
    input  logic                        wr_en,
    input  logic [ST_W-1:0]             status,
    input  logic [DATA_W-1:0]           cptr,
    input  logic [SEL_N-1:0][DATA_W-1:0] sel,
    output logic                        wr_ctrl,
    output logic                        wr_cptr,
    output logic [SEL_N-1:0]            wr_sel,
    output logic [DATA_W-1:0]           rd_data
);
    localparam int IDX_W = ADDR_W - 2;

    logic [IDX_W-1:0] idx;
    logic [1:0]       unused_low;

    assign idx        = addr[ADDR_W-1:2];
    assign unused_low = addr[1:0];
    assign wr_ctrl    = wr_en && (idx == IDX_W'(IDX_CTRL));
    assign wr_cptr    = wr_en && (idx == IDX_W'(IDX_CPTR));

    for (genvar g = 0; g < SEL_N; g++) begin : g_wsel
        assign wr_sel[g] = wr_en && (idx == IDX_W'(IDX_SEL0 + g));
    end

    always_comb begin
        rd_data = '0;
        if (idx == IDX_W'(IDX_STAT)) begin
            rd_data = {{(DATA_W-ST_W){1'b0}}, status};
        end else if (idx == IDX_W'(IDX_CPTR)) begin
            rd_data = cptr;
        end else begin
            for (int k = 0; k < SEL_N; k++) begin
                if (idx == IDX_W'(IDX_SEL0 + k)) begin
                    rd_data = sel[k];
                end
            end
        end
    end
endmodule

// File: rtl/dmareg_selreg.sv
module dmareg_selreg
    import dmareg_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic [DATA_W-1:0] d,
    output logic [DATA_W-1:0] q
);
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q <= '0;
        end else if (we) begin
            q <= d;
        end
    end

    assert_sel_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !we |=> $stable(q));
endmodule

// File: rtl/dmareg_chan.sv
module dmareg_chan
    import dmareg_pkg::*;
#(
    parameter int ADDR_W = 6,
    parameter int SEL_N  = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [31:0]       wr_data,
    output logic [31:0]       rd_data,
    input  logic              seq_kill,
    output logic [15:0]       status_o,
    output logic [31:0]       cmd_ptr_o,
    output logic [31:0]       intr_sel_o,
    output logic [31:0]       branch_sel_o,
    output logic [31:0]       wait_sel_o,
    output logic              kick_o,
    output logic              flush_o,
    output logic              fetch_o
);
    logic [ST_W-1:0]              status_q;
    logic [ST_W-1:0]              st_nxt;
    logic [DATA_W-1:0]            cptr_q;
    logic [SEL_N-1:0][DATA_W-1:0] sel_q;
    logic [SEL_N-1:0]             wr_sel;
    logic                         wr_ctrl;
    logic                         wr_cptr;
    logic                         cptr_take;
    logic                         kick_n;
    logic                         flush_n;
    logic                         kick_q;
    logic                         flush_q;
    logic                         fetch_q;

    dmareg_decode #(.ADDR_W(ADDR_W), .SEL_N(SEL_N)) u_dec (
        .addr    (addr),
        .wr_en   (wr_en),
        .status  (status_q),
        .cptr    (cptr_q),
        .sel     (sel_q),
        .wr_ctrl (wr_ctrl),
        .wr_cptr (wr_cptr),
        .wr_sel  (wr_sel),
        .rd_data (rd_data)
    );

    dmareg_status_merge u_merge (
        .cur     (status_q),
        .kill    (seq_kill),
        .wr      (wr_ctrl),
        .wdata   (wr_data),
        .nxt     (st_nxt),
        .kick_n  (kick_n),
        .flush_n (flush_n)
    );

    for (genvar g = 0; g < SEL_N; g++) begin : g_sel
        dmareg_selreg u_sel (
            .clk   (clk),
            .rst_n (rst_n),
            .we    (wr_sel[g]),
            .d     (wr_data),
            .q     (sel_q[g])
        );
    end

    assign cptr_take = wr_cptr && !status_q[B_ACT];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            status_q <= '0;
            cptr_q   <= '0;
            kick_q   <= 1'b0;
            flush_q  <= 1'b0;
            fetch_q  <= 1'b0;
        end else begin
            status_q <= st_nxt;
            kick_q   <= kick_n;
            flush_q  <= flush_n;
            fetch_q  <= cptr_take;
            if (cptr_take) begin
                cptr_q <= {wr_data[DATA_W-1:ALIGN_B], {ALIGN_B{1'b0}}};
            end
        end
    end

    assign status_o     = status_q;
    assign cmd_ptr_o    = cptr_q;
    assign intr_sel_o   = sel_q[0];
    assign branch_sel_o = sel_q[1];
    assign wait_sel_o   = sel_q[2];
    assign kick_o       = kick_q;
    assign flush_o      = flush_q;
    assign fetch_o      = fetch_q;

    assert_pause_blocks_active_R3: assert property (@(posedge clk) disable iff (!rst_n)
        status_q[B_PAUSE] |-> !status_q[B_ACT]);
    assert_run_fall_clears_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(status_q[B_RUN]) |-> (!status_q[B_ACT] && !status_q[B_DEAD]));
    assert_kick_active_R5: assert property (@(posedge clk) disable iff (!rst_n)
        kick_q |-> status_q[B_ACT]);
    assert_cptr_frozen_R6: assert property (@(posedge clk) disable iff (!rst_n)
        status_q[B_ACT] |=> ($stable(cptr_q) && !fetch_q));
    assert_kill_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (seq_kill && !wr_ctrl) |=> (status_q[B_DEAD] && !status_q[B_ACT]));
endmodule

// File: tb/dmareg_chan_test.sv
`timescale 1ns/1ps
module dmareg_chan_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [5:0]  addr = '0;
    logic [31:0] wr_data = '0;
    logic [31:0] rd_data;
    logic        seq_kill = 1'b0;
    logic [15:0] status_o;
    logic [31:0] cmd_ptr_o, intr_sel_o, branch_sel_o, wait_sel_o;
    logic        kick_o, flush_o, fetch_o;

    int checks = 0;
    int failures = 0;
    logic [15:0] exp_st = '0;

    always #2 clk = ~clk;

    dmareg_chan uut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wr_data(wr_data),
        .rd_data(rd_data), .seq_kill(seq_kill), .status_o(status_o),
        .cmd_ptr_o(cmd_ptr_o), .intr_sel_o(intr_sel_o), .branch_sel_o(branch_sel_o),
        .wait_sel_o(wait_sel_o), .kick_o(kick_o), .flush_o(flush_o), .fetch_o(fetch_o)
    );

    task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            failures++;
            $display("FAIL %s got=%h exp=%h", req, got, exp);
        end
    endtask

    // returns {kick, flush, status}
    function automatic logic [17:0] ref_step(input logic [15:0] cur, input logic kill,
                                             input logic wr, input logic [31:0] wd);
        logic [15:0] b, s;
        logic fl;
        b = cur;
        if (kill) begin b[11] = 1'b1; b[10] = 1'b0; end
        if (!wr) return {2'b00, b};
        s = (wd[15:0] & 16'hF0FF & wd[31:16]) | (b & ~wd[31:16]);
        fl = 1'b0;
        if (s[12]) s[10] = 1'b1;
        if (s[15]) begin s[10] = 1'b1; s[11] = 1'b0; end
        if (s[14]) s[10] = 1'b0;
        if (b[15] && !s[15]) begin
            s[10] = 1'b0; s[11] = 1'b0;
            if (s[13]) begin fl = 1'b1; s[13] = 1'b0; end
        end
        if (s[13]) fl = 1'b1;
        return {s[10], fl, s};
    endfunction

    task automatic ctrl_write(input string req, input logic [31:0] wd, input logic kill);
        logic [17:0] r;
        r = ref_step(exp_st, kill, 1'b1, wd);
        @(negedge clk);
        addr = 6'd0; wr_data = wd; wr_en = 1'b1; seq_kill = kill;
        @(negedge clk);
        wr_en = 1'b0; seq_kill = 1'b0;
        exp_st = r[15:0];
        check({req, " status"}, {16'h0, status_o}, {16'h0, r[15:0]});
        check({req, " kick"}, {31'h0, kick_o}, {31'h0, r[17]});
        check({req, " flush"}, {31'h0, flush_o}, {31'h0, r[16]});
    endtask

    task automatic plain_write(input logic [5:0] a, input logic [31:0] wd);
        @(negedge clk);
        addr = a; wr_data = wd; wr_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [5:0] a, output logic [31:0] v);
        @(negedge clk);
        addr = a;
        #1 v = rd_data;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        failures++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        logic [31:0] v;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        check("R1 status", {16'h0, status_o}, 32'h0);
        check("R1 cptr", cmd_ptr_o, 32'h0);
        check("R1 sels", intr_sel_o | branch_sel_o | wait_sel_o, 32'h0);
        check("R1 pulses", {29'h0, kick_o, flush_o, fetch_o}, 32'h0);
        for (int i = 0; i < 16; i++) begin
            rd(6'(i * 4), v);
            check("R1 read zero", v, 32'h0);
        end

        // R10, R8: select registers, address low bits ignored
        plain_write(6'd13, 32'hA5A5_0F0F);
        plain_write(6'd18, 32'h1234_8765);
        plain_write(6'd23, 32'hFFFF_0001);
        check("R10 intr sel", intr_sel_o, 32'hA5A5_0F0F);
        check("R10 branch sel", branch_sel_o, 32'h1234_8765);
        check("R10 wait sel", wait_sel_o, 32'hFFFF_0001);
        for (int o = 0; o < 4; o++) begin
            rd(6'(12 + o), v);
            check("R8 read isel any offset", v, 32'hA5A5_0F0F);
            rd(6'(20 + o), v);
            check("R8 read wsel any offset", v, 32'hFFFF_0001);
        end
        // R10 status write ignored
        plain_write(6'd4, 32'hFFFF_FFFF);
        check("R10 status write ignored", {16'h0, status_o}, 32'h0);
        // R7 unused slots: writes have no effect, read zero
        for (int i = 6; i < 16; i++) plain_write(6'(i * 4), 32'hDEAD_BEEF);
        for (int i = 6; i < 16; i++) begin
            rd(6'(i * 4 + 1), v);
            check("R7 unused reads zero", v, 32'h0);
        end
        check("R7 sels untouched", intr_sel_o ^ 32'hA5A5_0F0F, 32'h0);

        // R6 pointer load while idle
        @(negedge clk);
        addr = 6'd8; wr_data = 32'h1234_567F; wr_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0;
        check("R6 aligned ptr", cmd_ptr_o, 32'h1234_5670);
        check("R6 fetch pulse", {31'h0, fetch_o}, 32'h1);
        @(negedge clk);
        check("R6 fetch one cycle", {31'h0, fetch_o}, 32'h0);
        rd(6'd8, v);
        check("R7 read ptr", v, 32'h1234_5670);

        // R3 RUN -> ACTIVE; R6 pointer frozen while active
        ctrl_write("R3 run", 32'h8000_8000, 1'b0);
        @(negedge clk);
        addr = 6'd8; wr_data = 32'h0000_0100; wr_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0;
        check("R6 ptr frozen", cmd_ptr_o, 32'h1234_5670);
        check("R6 no fetch", {31'h0, fetch_o}, 32'h0);
        rd(6'd0, v);
        check("R7 ctrl reads zero", v, 32'h0);
        rd(6'd4, v);
        check("R7 status readback", v, {16'h0, exp_st});

        // R9 kill alone, then RUN clears DEAD
        @(negedge clk);
        seq_kill = 1'b1;
        @(negedge clk);
        seq_kill = 1'b0;
        exp_st = ref_step(exp_st, 1'b1, 1'b0, 32'h0);
        check("R9 kill status", {16'h0, status_o}, {16'h0, exp_st});
        check("R9 dead set", {31'h0, status_o[11]}, 32'h1);
        ctrl_write("R9 run after kill", 32'h8000_8000, 1'b0);
        // R4 RUN falls with FLUSH set
        ctrl_write("R4 set flush", 32'h2000_2000, 1'b0);
        ctrl_write("R4 run fall", 32'h8000_0000, 1'b0);
        check("R4 flush cleared", {31'h0, status_o[13]}, 32'h0);
        check("R4 flush pulse", {31'h0, flush_o}, 32'h1);

        // R2..R5, R9 sweep over control nibble values and enables
        for (int a = 0; a < 16; a++) begin
            for (int b = 0; b < 16; b++) begin
                logic [15:0] m, val;
                logic k;
                m   = {4'(b), (((a + b) % 4) == 0) ? 4'hC : 4'h0, 8'((a * 17) & 255)};
                val = {4'(a), 4'hC, 8'((a * 29 + b * 7) & 255)};
                k   = (((a * 16 + b) % 5) == 0);
                ctrl_write("R2 R3 R4 R5 R9 sweep", {m, val}, k);
            end
        end

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule